// File: doc/BRIEF.md
# SDRAM Bank State Tracker

This block sits beside a memory controller's command scheduler and follows the command stream sent to a multi-bank SDRAM. For every bank it records whether a row is open, which row that is, and how far the bank is through a pending auto precharge or a precharge recovery. From that record it produces registered per-bank permission flags. One flag says an activate would be accepted, and the other says a read or write would be accepted. It also produces a row-hit flag for a lookup port and a one-cycle error pulse when the stream breaks the bank rules.

Banks are independent of one another. Each holds its own open row, and opening one bank never requires closing another. A read or write with auto precharge closes its bank by itself. The precharge is taken to begin a fixed number of cycles after the access, which models the end of the burst. A fresh activate to that bank is then held off until the recovery time has also run out. The tracker issues no commands of its own and does not deal with refresh, power-up or data timing.

Top module: `sdram_bank_tracker`

## Requirements
- R1: While `rst` is high and after its release, every bank is idle with recovery expired: `act_ok` is all ones, `rw_ok` is all zeros, and `row_hit` and `proto_err` are low.
- R2: `cmd_op` is coded 0 none, 1 activate, 2 read, 3 write, 4 read with auto precharge, 5 write with auto precharge, 6 precharge one bank, 7 precharge all. An activate accepted at clock edge n opens `cmd_bank` with `cmd_row`, and `rw_ok` for that bank is high after edge n.
- R3: A command to one bank leaves the state and flags of every other bank unchanged.
- R4: After edge n, `act_ok[b]` is high exactly when an activate to bank b at edge n+1 would be accepted.
- R5: A precharge to bank b at edge n closes b. An activate to b is refused before edge n+TRP and accepted from edge n+TRP on.
- R6: A read or write with auto precharge at edge n to an open bank closes it at once. Its recovery starts at edge n+AP_DELAY, so an activate is accepted from edge n+AP_DELAY+TRP on.
- R7: After edge n, `row_hit` is high exactly when `look_bank` (sampled at edge n) is open after that edge and its stored row equals `look_row`.
- R8: A read or write of any kind to a bank that is not open, or an activate to a bank whose `act_ok` is low, raises `proto_err` for the one cycle after that edge. The command then has no effect on any bank.
- R9: Precharge all moves every bank, open or not, into recovery starting at that edge.
- R10: A plain read or write to an open bank keeps it open with the same row.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_op | input | 3 | Command code, see R2 |
| cmd_bank | input | $clog2(NUM_BANKS) | Bank addressed by the command |
| cmd_row | input | ROW_W | Row address for activate |
| look_bank | input | $clog2(NUM_BANKS) | Bank for the row-hit lookup |
| look_row | input | ROW_W | Row for the row-hit lookup |
| act_ok | output | NUM_BANKS | Activate would be accepted next cycle, per bank |
| rw_ok | output | NUM_BANKS | Bank is open and accepts reads and writes |
| row_hit | output | 1 | Lookup bank is open on the lookup row |
| proto_err | output | 1 | Illegal command seen at the previous edge |

## Verification
Every output is a register, so the result of a command sampled at edge n is due after edge n and is valid until edge n+1. The bench drives each command on a falling edge and advances its behavioural model at the following rising edge. It compares all four outputs on the next falling edge, one cycle after the stimulus. Recovery windows are checked by counting edges from the precharge or auto-precharge access. The bench probes activates one edge before and exactly at the permitted edge, so an off-by-one in TRP or AP_DELAY shows up as a wrong `act_ok` or a spurious `proto_err`.

// File: rtl/sbt_pkg.sv
package sbt_pkg;

  typedef enum logic [2:0] {
    OP_NOP  = 3'd0,
    OP_ACT  = 3'd1,
    OP_RD   = 3'd2,
    OP_WR   = 3'd3,
    OP_RDA  = 3'd4,
    OP_WRA  = 3'd5,
    OP_PRE  = 3'd6,
    OP_PREA = 3'd7
  } sbt_op_e;

  typedef enum logic [1:0] {
    BK_IDLE    = 2'd0,
    BK_OPEN    = 2'd1,
    BK_APWAIT  = 2'd2,
    BK_RECOVER = 2'd3
  } sbt_bank_e;

endpackage

// File: rtl/sbt_cmd_decode.sv
module sbt_cmd_decode
  import sbt_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  localparam int BANK_W = $clog2(NUM_BANKS)
) (
  input  logic [2:0]           op,
  input  logic [BANK_W-1:0]    bank,
  output logic [NUM_BANKS-1:0] act_sel,
  output logic [NUM_BANKS-1:0] rw_sel,
  output logic [NUM_BANKS-1:0] ap_sel,
  output logic [NUM_BANKS-1:0] pre_sel
);

  sbt_op_e opc;
  logic    is_act, is_rw, is_ap, is_pre, is_prea;

  always_comb begin
    opc     = sbt_op_e'(op);
    is_act  = (opc == OP_ACT);
    is_ap   = (opc == OP_RDA) || (opc == OP_WRA);
    is_rw   = (opc == OP_RD) || (opc == OP_WR) || is_ap;
    is_pre  = (opc == OP_PRE);
    is_prea = (opc == OP_PREA);
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_sel
    logic hit;
    assign hit        = (bank == BANK_W'(b));
    assign act_sel[b] = is_act & hit;
    assign rw_sel[b]  = is_rw & hit;
    assign ap_sel[b]  = is_ap & hit;
    assign pre_sel[b] = is_prea | (is_pre & hit);
  end

endmodule

// File: rtl/sbt_bank.sv
module sbt_bank
  import sbt_pkg::*;
#(
  parameter int ROW_W    = 13,
  parameter int TRP      = 3,
  parameter int AP_DELAY = 4,
  localparam int CNT_MAX = (TRP > AP_DELAY) ? TRP : AP_DELAY,
  localparam int CNT_W   = $clog2(CNT_MAX + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             act_sel,
  input  logic             ap_sel,
  input  logic             pre_sel,
  input  logic [ROW_W-1:0] row_in,
  output logic             act_legal,
  output logic             rw_legal,
  output logic             nxt_act_ok,
  output logic             nxt_open,
  output logic [ROW_W-1:0] nxt_row
);

  sbt_bank_e        st, st_n;
  logic [CNT_W-1:0] cnt, cnt_n;
  logic [ROW_W-1:0] row_q;
  logic             take_act, take_ap;

  assign act_legal = (st == BK_IDLE) || ((st == BK_RECOVER) && (cnt == '0));
  assign rw_legal  = (st == BK_OPEN);
  assign take_act  = act_sel & act_legal;
  assign take_ap   = ap_sel & rw_legal;

  always_comb begin
    st_n    = st;
    cnt_n   = cnt;
    nxt_row = row_q;
    unique case (st)
      BK_IDLE: begin
        cnt_n = '0;
        if (take_act) begin
          st_n    = BK_OPEN;
          nxt_row = row_in;
        end
      end
      BK_OPEN: begin
        if (take_ap) begin
          st_n  = BK_APWAIT;
          cnt_n = CNT_W'(AP_DELAY - 1);
        end
      end
      BK_APWAIT: begin
        if (cnt == '0) begin
          st_n  = BK_RECOVER;
          cnt_n = CNT_W'(TRP - 1);
        end else begin
          cnt_n = cnt - CNT_W'(1);
        end
      end
      BK_RECOVER: begin
        if (take_act) begin
          st_n    = BK_OPEN;
          nxt_row = row_in;
        end else if (cnt == '0) begin
          st_n = BK_IDLE;
        end else begin
          cnt_n = cnt - CNT_W'(1);
        end
      end
      default: st_n = BK_IDLE;
    endcase
    if (pre_sel) begin
      st_n  = BK_RECOVER;
      cnt_n = CNT_W'(TRP - 1);
    end
  end

  assign nxt_open   = (st_n == BK_OPEN);
  assign nxt_act_ok = (st_n == BK_IDLE) || ((st_n == BK_RECOVER) && (cnt_n == '0));

  always_ff @(posedge clk) begin
    if (rst) begin
      st    <= BK_IDLE;
      cnt   <= '0;
      row_q <= '0;
    end else begin
      st    <= st_n;
      cnt   <= cnt_n;
      row_q <= nxt_row;
    end
  end

endmodule

// File: rtl/sbt_row_match.sv
module sbt_row_match #(
  parameter int NUM_BANKS = 4,
  parameter int ROW_W     = 13,
  localparam int BANK_W = $clog2(NUM_BANKS)
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic [NUM_BANKS-1:0]             bank_open,
  input  logic [NUM_BANKS-1:0][ROW_W-1:0]  bank_row,
  input  logic [BANK_W-1:0]                look_bank,
  input  logic [ROW_W-1:0]                 look_row,
  output logic                             hit
);

  logic hit_n;

  assign hit_n = bank_open[look_bank] && (bank_row[look_bank] == look_row);

  always_ff @(posedge clk) begin
    if (rst) hit <= 1'b0;
    else     hit <= hit_n;
  end

endmodule

// File: rtl/sdram_bank_tracker.sv
module sdram_bank_tracker
  import sbt_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int ROW_W     = 13,
  parameter int TRP       = 3,
  parameter int AP_DELAY  = 4,
  localparam int BANK_W = $clog2(NUM_BANKS)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [2:0]           cmd_op,
  input  logic [BANK_W-1:0]    cmd_bank,
  input  logic [ROW_W-1:0]     cmd_row,
  input  logic [BANK_W-1:0]    look_bank,
  input  logic [ROW_W-1:0]     look_row,
  output logic [NUM_BANKS-1:0] act_ok,
  output logic [NUM_BANKS-1:0] rw_ok,
  output logic                 row_hit,
  output logic                 proto_err
);

  logic [NUM_BANKS-1:0]            act_sel, rw_sel, ap_sel, pre_sel;
  logic [NUM_BANKS-1:0]            act_legal, rw_legal;
  logic [NUM_BANKS-1:0]            nxt_act_ok, nxt_open;
  logic [NUM_BANKS-1:0][ROW_W-1:0] nxt_row;
  logic                            err_n;

  sbt_cmd_decode #(.NUM_BANKS(NUM_BANKS)) u_dec (
    .op      (cmd_op),
    .bank    (cmd_bank),
    .act_sel (act_sel),
    .rw_sel  (rw_sel),
    .ap_sel  (ap_sel),
    .pre_sel (pre_sel)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    sbt_bank #(.ROW_W(ROW_W), .TRP(TRP), .AP_DELAY(AP_DELAY)) u_bank (
      .clk        (clk),
      .rst        (rst),
      .act_sel    (act_sel[b]),
      .ap_sel     (ap_sel[b]),
      .pre_sel    (pre_sel[b]),
      .row_in     (cmd_row),
      .act_legal  (act_legal[b]),
      .rw_legal   (rw_legal[b]),
      .nxt_act_ok (nxt_act_ok[b]),
      .nxt_open   (nxt_open[b]),
      .nxt_row    (nxt_row[b])
    );
  end

  sbt_row_match #(.NUM_BANKS(NUM_BANKS), .ROW_W(ROW_W)) u_match (
    .clk       (clk),
    .rst       (rst),
    .bank_open (nxt_open),
    .bank_row  (nxt_row),
    .look_bank (look_bank),
    .look_row  (look_row),
    .hit       (row_hit)
  );

  assign err_n = |(act_sel & ~act_legal) | |(rw_sel & ~rw_legal);

  always_ff @(posedge clk) begin
    if (rst) begin
      act_ok    <= '1;
      rw_ok     <= '0;
      proto_err <= 1'b0;
    end else begin
      act_ok    <= nxt_act_ok;
      rw_ok     <= nxt_open;
      proto_err <= err_n;
    end
  end

endmodule

// File: rtl/sbt_chk.sv
module sbt_chk #(
  parameter int NUM_BANKS = 4,
  localparam int BANK_W = $clog2(NUM_BANKS)
) (
  input logic                 clk,
  input logic                 rst,
  input logic [2:0]           cmd_op,
  input logic [BANK_W-1:0]    cmd_bank,
  input logic [BANK_W-1:0]    look_bank,
  input logic [NUM_BANKS-1:0] act_ok,
  input logic [NUM_BANKS-1:0] rw_ok,
  input logic                 row_hit,
  input logic                 proto_err
);

  logic [BANK_W-1:0] last_bank, last_look;
  logic              bad_act, bad_rw;

  always_ff @(posedge clk) begin
    last_bank <= cmd_bank;
    last_look <= look_bank;
  end

  assign bad_act = (cmd_op == 3'd1) && !act_ok[cmd_bank];
  assign bad_rw  = (cmd_op >= 3'd2) && (cmd_op <= 3'd5) && !rw_ok[cmd_bank];

  AST_BAD_ACT_FLAGGED: assert property (@(posedge clk) disable iff (rst)
    bad_act |=> proto_err); // R8

  AST_BAD_RW_FLAGGED: assert property (@(posedge clk) disable iff (rst)
    bad_rw |=> proto_err); // R8

  AST_ACT_OPENS: assert property (@(posedge clk) disable iff (rst)
    ((cmd_op == 3'd1) && act_ok[cmd_bank]) |=> rw_ok[last_bank]); // R2

  AST_PRE_CLOSES: assert property (@(posedge clk) disable iff (rst)
    (cmd_op == 3'd6) |=> !rw_ok[last_bank]); // R5

  AST_PREA_CLOSES_ALL: assert property (@(posedge clk) disable iff (rst)
    (cmd_op == 3'd7) |=> (rw_ok == '0)); // R9

  AST_HIT_NEEDS_OPEN: assert property (@(posedge clk) disable iff (rst)
    row_hit |-> rw_ok[last_look]); // R7

  AST_ERR_NEEDS_CMD: assert property (@(posedge clk) disable iff (rst)
    proto_err |-> ($past(cmd_op) != 3'd0)); // R8

endmodule

bind sdram_bank_tracker sbt_chk #(.NUM_BANKS(NUM_BANKS)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .cmd_op    (cmd_op),
  .cmd_bank  (cmd_bank),
  .look_bank (look_bank),
  .act_ok    (act_ok),
  .rw_ok     (rw_ok),
  .row_hit   (row_hit),
  .proto_err (proto_err)
);

// File: tb/sdram_bank_tracker_tb.sv
`timescale 1ns/1ps
module sdram_bank_tracker_tb;

  localparam int NB  = 4;
  localparam int RW  = 13;
  localparam int TRP = 3;
  localparam int APD = 4;
  localparam int BW  = $clog2(NB);

  localparam int NOP = 0, ACT = 1, RD = 2, WR = 3, RDA = 4, WRA = 5, PRE = 6, PREA = 7;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [2:0]    cmd_op = '0;
  logic [BW-1:0] cmd_bank = '0;
  logic [RW-1:0] cmd_row = '0;
  logic [BW-1:0] look_bank = '0;
  logic [RW-1:0] look_row = '0;
  logic [NB-1:0] act_ok, rw_ok;
  logic          row_hit, proto_err;

  always #2.5 clk = ~clk;

  sdram_bank_tracker #(.NUM_BANKS(NB), .ROW_W(RW), .TRP(TRP), .AP_DELAY(APD)) u_dut (
    .clk(clk), .rst(rst), .cmd_op(cmd_op), .cmd_bank(cmd_bank), .cmd_row(cmd_row),
    .look_bank(look_bank), .look_row(look_row), .act_ok(act_ok), .rw_ok(rw_ok),
    .row_hit(row_hit), .proto_err(proto_err)
  );

  int checks = 0;
  int failures = 0;
  bit done = 0;

  // behavioural reference state
  int  edge_n;
  bit  m_open [NB];
  bit  m_apw  [NB];
  int  m_row  [NB];
  int  m_close[NB];
  int  m_ready[NB];
  bit  e_err;
  bit  e_hit;

  function automatic void model_reset();
    edge_n = 0;
    e_err = 0;
    e_hit = 0;
    for (int b = 0; b < NB; b++) begin
      m_open[b] = 0; m_apw[b] = 0; m_row[b] = 0; m_close[b] = -1; m_ready[b] = 0;
    end
  endfunction

  function automatic void model_edge(int op, int bk, int row, int lb, int lr);
    bit act_legal, rw_legal;
    int n = edge_n;
    act_legal = !m_open[bk] && !m_apw[bk] && (n >= m_ready[bk]);
    rw_legal  = m_open[bk];
    e_err = ((op == ACT) && !act_legal) || ((op >= RD) && (op <= WRA) && !rw_legal);
    for (int b = 0; b < NB; b++)
      if (m_apw[b] && (n == m_close[b])) begin
        m_apw[b] = 0; m_ready[b] = n + TRP;
      end
    case (op)
      ACT: if (act_legal) begin m_open[bk] = 1; m_row[bk] = row; end
      RDA, WRA: if (rw_legal) begin m_open[bk] = 0; m_apw[bk] = 1; m_close[bk] = n + APD; end
      PRE: begin m_open[bk] = 0; m_apw[bk] = 0; m_ready[bk] = n + TRP; end
      PREA: for (int b = 0; b < NB; b++) begin
        m_open[b] = 0; m_apw[b] = 0; m_ready[b] = n + TRP;
      end
      default: ;
    endcase
    e_hit = m_open[lb] && (m_row[lb] == lr);
    edge_n = n + 1;
  endfunction

  task automatic check_outputs(string tag);
    logic [NB-1:0] ea, er;
    for (int b = 0; b < NB; b++) begin
      ea[b] = !m_open[b] && !m_apw[b] && (edge_n >= m_ready[b]);
      er[b] = m_open[b];
    end
    checks += 4;
    if (act_ok !== ea) begin
      failures++;
      $display("FAIL %s/R4 act_ok got %b exp %b at edge %0d", tag, act_ok, ea, edge_n);
    end
    if (rw_ok !== er) begin
      failures++;
      $display("FAIL %s/R2 rw_ok got %b exp %b at edge %0d", tag, rw_ok, er, edge_n);
    end
    if (row_hit !== e_hit) begin
      failures++;
      $display("FAIL %s/R7 row_hit got %b exp %b at edge %0d", tag, row_hit, e_hit, edge_n);
    end
    if (proto_err !== e_err) begin
      failures++;
      $display("FAIL %s/R8 proto_err got %b exp %b at edge %0d", tag, proto_err, e_err, edge_n);
    end
  endtask

  // called on a falling edge: drive, let the rising edge pass, compare on the next falling edge
  task automatic step(int op, int bk, int row, int lb, int lr, string tag);
    cmd_op = 3'(op); cmd_bank = BW'(bk); cmd_row = RW'(row);
    look_bank = BW'(lb); look_row = RW'(lr);
    @(posedge clk);
    model_edge(op, bk, row, lb, lr);
    @(negedge clk);
    check_outputs(tag);
  endtask

  task automatic idle_steps(int cnt, int lb, int lr, string tag);
    for (int i = 0; i < cnt; i++) step(NOP, 0, 0, lb, lr, tag);
  endtask

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check_outputs("R1");

    // open two banks independently
    step(ACT, 0, 'h123, 0, 'h123, "R2");
    step(ACT, 1, 'h055, 0, 'h123, "R3");
    step(RD,  0, 0,     0, 'h124, "R10");
    step(WR,  0, 0,     0, 'h123, "R10");
    // activate to an open bank is refused and keeps the old row
    step(ACT, 0, 'h777, 0, 'h123, "R8");
    step(NOP, 0, 0,     0, 'h777, "R8");
    // access to an idle bank
    step(RD,  2, 0,     2, 0, "R8");
    step(WRA, 3, 0,     3, 0, "R8");

    // auto precharge on bank 1, others untouched
    step(RDA, 1, 0,     1, 'h055, "R6");
    step(ACT, 3, 'h0aa, 3, 'h0aa, "R3");
    step(ACT, 1, 'h011, 1, 'h011, "R6");
    idle_steps(APD + TRP - 3, 1, 'h011, "R6");
    step(ACT, 1, 'h011, 1, 'h011, "R6");
    step(ACT, 1, 'h012, 1, 'h011, "R6");

    // explicit precharge on bank 0: one edge early, then exact
    step(PRE, 0, 0,     0, 'h123, "R5");
    idle_steps(TRP - 2, 0, 0, "R5");
    step(ACT, 0, 'h200, 0, 'h200, "R5");
    step(ACT, 0, 'h200, 0, 'h200, "R5");

    // write with auto precharge
    step(WRA, 0, 0,     0, 'h200, "R6");
    idle_steps(APD + TRP, 0, 0, "R6");

    // precharge all with several banks open
    step(ACT, 2, 'h300, 2, 'h300, "R9");
    step(PREA, 0, 0,    2, 'h300, "R9");
    step(ACT, 2, 'h300, 2, 'h300, "R9");
    idle_steps(TRP - 2, 2, 'h300, "R9");
    step(ACT, 2, 'h301, 2, 'h301, "R9");
    // precharge of an idle bank restarts recovery
    step(PRE, 1, 0,     1, 0, "R5");
    step(ACT, 1, 'h001, 1, 'h001, "R5");

    // mixed traffic
    for (int i = 0; i < 600; i++)
      step($urandom_range(0, 7), $urandom_range(0, NB - 1), $urandom_range(0, 3),
           $urandom_range(0, NB - 1), $urandom_range(0, 3), "R3");

    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule